// File: doc/BRIEF.md
# Dual-Rail Phase-Coded Gate Cell

This block is a vector of gate cells for a four-state, delay-insensitive signalling scheme. Each logical bit travels on two wires, rail a and rail b. Together the two rails carry both the logical value and a phase bit. Rail a holds the value, and the exclusive-or of the two rails gives the phase. The cell works as a two-input AND, a two-input OR or a single-input INV, picked per cycle by a mode input. A fourth mode freezes the output. The AND and OR functions produce a new result only when both inputs sit in the same phase, and the result is issued in that phase. While the inputs disagree in phase, the cell keeps its last output. This models the local memory that a self-timed gate needs to ignore inputs that are still in transit.

The memory is modelled as a clocked register that is enabled by the phase-agreement test. Each bit position is an independent cell. Two helpers sit beside the gates. The first is a phase flipper on the first operand, which changes the phase and keeps the value. The second is a phase monitor on the output, which reports the phase of every output bit.

Top module: `tworail_gate`

## Requirements
- R1: A synchronous active-high `rst` clears every output bit to value 0 in phase 0, which is rails (a,b) = (0,0), at the next rising clock edge.
- R2: Codes are (a,b): value 1 in phase 0 = (1,1), value 1 in phase 1 = (1,0), value 0 in phase 0 = (0,0), value 0 in phase 1 = (0,1). With `op_sel` = 2'b00 (AND), when both operands of a bit share a phase, that bit's output one clock later carries the AND of the two values in that same phase.
- R3: With `op_sel` = 2'b01 (OR), when both operands of a bit share a phase, that bit's output one clock later carries the OR of the two values in that phase.
- R4: In AND or OR mode, a bit whose two operands are in different phases keeps its previous output code unchanged.
- R5: With `op_sel` = 2'b10 (INV), each bit updates every clock to the inverse of both rails of operand x. The value is inverted and the phase is kept. Operand z has no effect.
- R6: With `op_sel` = 2'b11 (freeze), every output bit keeps its code, whatever the operands are.
- R7: `xflip_a`/`xflip_b` present operand x with its phase inverted and its value kept (rail a passed, rail b inverted), combinationally.
- R8: `y_phase` reports the phase (rail a XOR rail b) of each registered output bit.
- R9: Bit positions are independent. One bit can update while another bit holds, in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Function: 00 AND, 01 OR, 10 INV, 11 freeze |
| x_a | input | WIDTH | Operand x, value rail |
| x_b | input | WIDTH | Operand x, second rail |
| z_a | input | WIDTH | Operand z, value rail |
| z_b | input | WIDTH | Operand z, second rail |
| y_a | output | WIDTH | Registered result, value rail |
| y_b | output | WIDTH | Registered result, second rail |
| y_phase | output | WIDTH | Phase of each result bit |
| xflip_a | output | WIDTH | Operand x with phase flipped, value rail |
| xflip_b | output | WIDTH | Operand x with phase flipped, second rail |

## Verification
Some properties are checked on every clock outside reset. These are the value and phase of the AND, OR and INV results, the stability of a bit whose operands disagree in phase, the freeze mode, and the phase inversion done by the flipper. Other behaviours can only be shown by the bench's scenarios. These are the reset code itself, the full sixteen-pair code table for each two-input function, a reset in the middle of a run, and one bit updating while its neighbour holds. Each of these needs a known history or a chosen ordering of stimuli.

// File: rtl/tworail_pkg.sv
package tworail_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_INV  = 2'b10,
    OP_HOLD = 2'b11
  } gate_op_e;

  typedef struct packed {
    logic a;
    logic b;
  } rail_t;

  // Build a two-rail code from a logical value and a phase.
  function automatic rail_t make_code(input logic val, input logic ph);
    rail_t r;
    r.a = val;
    r.b = val ^ ph;
    return r;
  endfunction

endpackage

// File: rtl/tworail_phase_det.sv
module tworail_phase_det #(
  parameter int WIDTH = 1
) (
  input  logic [WIDTH-1:0] rail_a,
  input  logic [WIDTH-1:0] rail_b,
  output logic [WIDTH-1:0] phase
);
  assign phase = rail_a ^ rail_b;
endmodule

// File: rtl/tworail_phase_inv.sv
module tworail_phase_inv #(
  parameter int WIDTH = 1
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic [WIDTH-1:0] out_a,
  output logic [WIDTH-1:0] out_b
);
  // Value lives on rail a; flipping rail b alone moves the phase.
  assign out_a = in_a;
  assign out_b = ~in_b;
endmodule

// File: rtl/tworail_cell.sv
module tworail_cell
  import tworail_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  gate_op_e op,
  input  rail_t    x,
  input  rail_t    z,
  output rail_t    y
);
  localparam int NOPS = 2;

  logic [NOPS-1:0] ph;
  logic            same_ph;
  logic            upd;
  rail_t           nxt;

  tworail_phase_det #(.WIDTH(NOPS)) u_det (
    .rail_a ({x.a, z.a}),
    .rail_b ({x.b, z.b}),
    .phase  (ph)
  );

  assign same_ph = (ph[1] == ph[0]);

  always_comb begin
    upd = 1'b0;
    nxt = y;
    unique case (op)
      OP_AND: begin
        upd = same_ph;
        nxt = make_code(x.a & z.a, ph[1]);
      end
      OP_OR: begin
        upd = same_ph;
        nxt = make_code(x.a | z.a, ph[1]);
      end
      OP_INV: begin
        upd   = 1'b1;
        nxt.a = ~x.a;
        nxt.b = ~x.b;
      end
      default: begin
        upd = 1'b0;
        nxt = y;
      end
    endcase
  end

  // Hold memory: enabled only when the operands are phase-consistent.
  always_ff @(posedge clk) begin
    if (rst)      y <= '0;
    else if (upd) y <= nxt;
  end

  assert_and_value_R2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_AND && (x.a ^ x.b) == (z.a ^ z.b)) |=>
      (y.a == $past(x.a & z.a) && (y.a ^ y.b) == $past(x.a ^ x.b)));

  assert_or_value_R3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_OR && (x.a ^ x.b) == (z.a ^ z.b)) |=>
      (y.a == $past(x.a | z.a) && (y.a ^ y.b) == $past(z.a ^ z.b)));

  assert_mixed_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_AND || op == OP_OR) && (x.a ^ x.b) != (z.a ^ z.b)) |=> $stable(y));

  assert_inv_value_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INV) |=>
      (y.a != $past(x.a) && (y.a ^ y.b) == $past(x.a ^ x.b)));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(y));

endmodule

// File: rtl/tworail_gate.sv
module tworail_gate
  import tworail_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] x_a,
  input  logic [WIDTH-1:0] x_b,
  input  logic [WIDTH-1:0] z_a,
  input  logic [WIDTH-1:0] z_b,
  output logic [WIDTH-1:0] y_a,
  output logic [WIDTH-1:0] y_b,
  output logic [WIDTH-1:0] y_phase,
  output logic [WIDTH-1:0] xflip_a,
  output logic [WIDTH-1:0] xflip_b
);
  gate_op_e op_e;
  assign op_e = gate_op_e'(op_sel);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    rail_t xi, zi, yi;
    assign xi.a = x_a[i];
    assign xi.b = x_b[i];
    assign zi.a = z_a[i];
    assign zi.b = z_b[i];

    tworail_cell u_cell (
      .clk (clk),
      .rst (rst),
      .op  (op_e),
      .x   (xi),
      .z   (zi),
      .y   (yi)
    );

    assign y_a[i] = yi.a;
    assign y_b[i] = yi.b;
  end

  tworail_phase_det #(.WIDTH(WIDTH)) u_out_det (
    .rail_a (y_a),
    .rail_b (y_b),
    .phase  (y_phase)
  );

  tworail_phase_inv #(.WIDTH(WIDTH)) u_flip (
    .in_a  (x_a),
    .in_b  (x_b),
    .out_a (xflip_a),
    .out_b (xflip_b)
  );

  assert_flip_phase_R7: assert property (@(posedge clk) disable iff (rst)
    (xflip_a == x_a) && ((xflip_a ^ xflip_b) == ~(x_a ^ x_b)));

  assert_out_phase_R8: assert property (@(posedge clk) disable iff (rst)
    ##1 (y_phase ^ y_b) == y_a);

endmodule

// File: tb/tworail_gate_test.sv
module tworail_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 2;
  localparam int NVEC = 38;

  // Entry: {op[1:0], xa, xb, za, zb, hold, ea, eb}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b00_11_11_0_11, 9'b00_11_10_1_00, 9'b00_11_00_0_00, 9'b00_11_01_1_00,
    9'b00_10_10_0_10, 9'b00_10_11_1_00, 9'b00_10_01_0_01, 9'b00_10_00_1_00,
    9'b00_00_11_0_00, 9'b00_00_10_1_00, 9'b00_00_00_0_00, 9'b00_00_01_1_00,
    9'b00_01_10_0_01, 9'b00_01_11_1_00, 9'b00_01_01_0_01, 9'b00_01_00_1_00,
    9'b01_11_11_0_11, 9'b01_11_10_1_00, 9'b01_11_00_0_11, 9'b01_11_01_1_00,
    9'b01_10_10_0_10, 9'b01_10_11_1_00, 9'b01_10_01_0_10, 9'b01_10_00_1_00,
    9'b01_00_11_0_11, 9'b01_00_10_1_00, 9'b01_00_00_0_00, 9'b01_00_01_1_00,
    9'b01_01_10_0_10, 9'b01_01_11_1_00, 9'b01_01_01_0_01, 9'b01_01_00_1_00,
    9'b10_11_00_0_00, 9'b10_00_00_0_11, 9'b10_10_00_0_01, 9'b10_01_00_0_10,
    9'b11_11_11_1_00, 9'b11_00_01_1_00
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_sel = 2'b00;
  logic [W-1:0] x_a = '0, x_b = '0, z_a = '0, z_b = '0;
  logic [W-1:0] y_a, y_b, y_phase, xflip_a, xflip_b;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tworail_gate #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .op_sel(op_sel),
    .x_a(x_a), .x_b(x_b), .z_a(z_a), .z_b(z_b),
    .y_a(y_a), .y_b(y_b), .y_phase(y_phase),
    .xflip_a(xflip_a), .xflip_b(xflip_b)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic [1:0] op, input logic [W-1:0] xa, xb, za, zb);
    op_sel = op; x_a = xa; x_b = xb; z_a = za; z_b = zb;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [1:0] prev;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset y", {4'b0, y_a, y_b}, 8'h00);
    check("R8 reset phase", {6'b0, y_phase}, 8'h00);
    prev = 2'b00;

    // R2..R6: full code table, both bits driven alike
    for (int i = 0; i < NVEC; i++) begin
      logic [8:0] v;
      logic [1:0] exp;
      string tag;
      v = VEC[i];
      step(v[8:7], {W{v[6]}}, {W{v[5]}}, {W{v[4]}}, {W{v[3]}});
      exp = v[2] ? prev : v[1:0];
      if (v[8:7] == 2'b11)     tag = "R6 freeze";
      else if (v[8:7] == 2'b10) tag = "R5 inv";
      else if (v[2])            tag = "R4 mixed hold";
      else if (v[8:7] == 2'b00) tag = "R2 and";
      else                      tag = "R3 or";
      check(tag, {4'b0, y_a, y_b}, {4'b0, {W{exp[1]}}, {W{exp[0]}}});
      check("R8 out phase", {6'b0, y_phase}, {6'b0, {W{exp[1] ^ exp[0]}}});
      prev = exp;
    end

    // R7: phase flipper, all four codes
    for (int c = 0; c < 4; c++) begin
      logic [1:0] cd;
      cd = c[1:0];
      x_a = {W{cd[1]}}; x_b = {W{cd[0]}};
      #1;
      check("R7 flip", {4'b0, xflip_a, xflip_b}, {4'b0, {W{cd[1]}}, {W{~cd[0]}}});
    end

    // R9: set both bits to (1,1) via INV of (0,0), then bit0 updates, bit1 holds
    step(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R5 inv setup", {4'b0, y_a, y_b}, 8'b0000_1111);
    step(2'b00, 2'b01, 2'b00, 2'b11, 2'b00);
    check("R9 independent", {4'b0, y_a, y_b}, 8'b0000_1110);
    check("R9 phase", {6'b0, y_phase}, 8'b0000_0001);

    // R5: operand z has no effect in INV mode
    step(2'b10, 2'b10, 2'b01, 2'b11, 2'b10);
    check("R5 z ignored", {4'b0, y_a, y_b}, 8'b0000_0110);

    // R6: freeze across several changing operand sets
    step(2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
    step(2'b11, 2'b00, 2'b01, 2'b10, 2'b00);
    check("R6 freeze run", {4'b0, y_a, y_b}, 8'b0000_0110);

    // R1: reset in mid-run
    rst = 1'b1;
    step(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    rst = 1'b0;
    check("R1 mid reset", {4'b0, y_a, y_b}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule